// File: doc/BRIEF.md
# Implicit Error Register Rename and Forwarding Unit

Every floating-point add in the core writes a rounding-error value into a single architectural error register, although the add instruction never names that register as a destination. This unit tracks that hidden destination. At rename it gives each add a fresh physical error entry and makes it the newest mapping, so that a later move-from-error reads the entry of the youngest add before it in program order. Adds may finish in any order. Each one writes its error back by tag, and a move whose entry is still pending sees the entry as not ready until that write arrives.

A small pool of physical entries holds the values. A free bitmap hands out the lowest-numbered free entry. Commit retires the mapping of an add and frees the entry it replaces. A flush returns the speculative mapping to the committed one. When a move reads an entry in the same cycle that the entry is written back, the read port forwards the incoming value, which covers an add in execute feeding a move in decode. A build-time option limits renaming to adds that carry a mark bit, so only adds whose error software will read use up entries. A save/restore port reads and overwrites the committed value for context switches.

Top module: `erb_rename`

## Requirements
- R1: After reset, both the speculative and committed mappings point at entry 0, and entry 0 holds +0.0 (all bits zero) and is ready.
- R2: An add that is renamed and not stalled takes the lowest-numbered free entry. That number appears on `rn_add_tag` in the same cycle and becomes `rn_mov_tag` in the next cycle.
- R3: A move presented together with an add counts as older than the add. `rn_mov_tag` shows the mapping from before that add.
- R4: `rn_stall` is high exactly when an add needs an entry and none is free. A stalled add leaves the mapping unchanged.
- R5: A writeback stores its value in the tagged entry and marks the entry ready. From the next cycle the read port returns that value with `rd_ready` high.
- R6: When a writeback and a read name the same tag in the same cycle, the read port returns the value being written and `rd_ready` is high.
- R7: An entry that has just been allocated reads as not ready until its writeback.
- R8: A commit makes its tag the committed mapping and frees the entry committed before it. `sv_rd_value` shows the value of the committed entry.
- R9: A flush sets the speculative mapping to the committed one, after any commit in the same cycle, and frees every other entry. An add presented in the flush cycle is not renamed.
- R10: With MODE = ERB_RN_MARKED, an add with `rn_add_mark` low takes no entry and leaves `rn_mov_tag` unchanged. With MODE = ERB_RN_ALL, every add is renamed.
- R11: A restore overwrites the committed entry and marks it ready. It takes priority over a writeback to the same entry, and `sv_rd_value` shows the new value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rn_add_valid | input | 1 | An add is at rename |
| rn_add_mark | input | 1 | The add's error will be read (marked-only mode) |
| rn_stall | output | 1 | Add cannot rename: no free entry |
| rn_add_tag | output | TAG_W | Entry given to the add |
| rn_mov_tag | output | TAG_W | Entry a move at rename must read |
| wb_valid | input | 1 | Error writeback strobe |
| wb_tag | input | TAG_W | Entry being written back |
| wb_value | input | DATA_W | Error value written back |
| rd_tag | input | TAG_W | Entry a move reads |
| rd_value | output | DATA_W | Value of the read entry, forwarded from writeback |
| rd_ready | output | 1 | Read entry holds its final value |
| cm_valid | input | 1 | A renamed add commits |
| cm_tag | input | TAG_W | Entry of the committing add |
| flush | input | 1 | Discard speculative mappings |
| sv_wr_valid | input | 1 | Restore strobe for the committed error |
| sv_wr_value | input | DATA_W | Value to restore |
| sv_rd_value | output | DATA_W | Committed error value for save |

## Verification
Two pairs of events can land in the same cycle. The first pair is a writeback and a read of the same tag: the bench drives a write of a known pattern to an entry that was just allocated while the read port names that entry, and it expects the pattern with ready high, not the stale value. The second pair is a commit and a flush: the random phase lets both strobes rise together, and the reference model expects the speculative mapping to land on the newly committed tag with every other entry freed. Each cycle the outputs are compared with the model, including cycles where an add stalls or is flushed and a move is present.

// File: rtl/erb_pkg.sv
package erb_pkg;
   typedef enum logic [0:0] {
      ERB_RN_ALL    = 1'b0,
      ERB_RN_MARKED = 1'b1
   } rn_mode_e;
endpackage

// File: rtl/erb_freelist.sv
module erb_freelist #(
   parameter int NUM_PHYS = 4,
   localparam int TAG_W = $clog2(NUM_PHYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alloc_en,
   input  logic                rel_en,
   input  logic [TAG_W-1:0]    rel_tag,
   input  logic                flush,
   input  logic [TAG_W-1:0]    keep_tag,
   output logic [TAG_W-1:0]    pick_tag,
   output logic                none_free,
   output logic [NUM_PHYS-1:0] free_vec
);
   logic [NUM_PHYS-1:0] free_q, free_d;

   always_comb begin
      pick_tag = '0;
      for (int i = NUM_PHYS - 1; i >= 0; i--) begin
         if (free_q[i]) pick_tag = TAG_W'(i);
      end
   end

   assign none_free = (free_q == '0);
   assign free_vec  = free_q;

   always_comb begin
      free_d = free_q;
      if (flush) begin
         free_d = '1;
         free_d[keep_tag] = 1'b0;
      end else begin
         if (alloc_en) free_d[pick_tag] = 1'b0;
         if (rel_en)   free_d[rel_tag]  = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) free_q <= {{(NUM_PHYS-1){1'b1}}, 1'b0};
      else        free_q <= free_d;
   end
endmodule

// File: rtl/erb_map.sv
module erb_map #(
   parameter int NUM_PHYS = 4,
   localparam int TAG_W = $clog2(NUM_PHYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_en,
   input  logic [TAG_W-1:0] alloc_tag,
   input  logic             cm_valid,
   input  logic [TAG_W-1:0] cm_tag,
   input  logic             flush,
   output logic [TAG_W-1:0] spec_tag,
   output logic [TAG_W-1:0] comm_tag,
   output logic [TAG_W-1:0] comm_next
);
   logic [TAG_W-1:0] spec_q, comm_q;

   assign comm_next = cm_valid ? cm_tag : comm_q;
   assign spec_tag  = spec_q;
   assign comm_tag  = comm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spec_q <= '0;
         comm_q <= '0;
      end else begin
         comm_q <= comm_next;
         if (flush)         spec_q <= comm_next;
         else if (alloc_en) spec_q <= alloc_tag;
      end
   end
endmodule

// File: rtl/erb_store.sv
module erb_store #(
   parameter int NUM_PHYS = 4,
   parameter int DATA_W   = 32,
   localparam int TAG_W = $clog2(NUM_PHYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic              wb_valid,
   input  logic [TAG_W-1:0]  wb_tag,
   input  logic [DATA_W-1:0] wb_value,
   input  logic              rs_valid,
   input  logic [TAG_W-1:0]  rs_tag,
   input  logic [DATA_W-1:0] rs_value,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_value,
   output logic              rd_ready,
   input  logic [TAG_W-1:0]  sv_tag,
   output logic [DATA_W-1:0] sv_value
);
   logic [DATA_W-1:0]   data_q [NUM_PHYS];
   logic [NUM_PHYS-1:0] rdy_q;

   for (genvar e = 0; e < NUM_PHYS; e++) begin : g_ent
      localparam logic [TAG_W-1:0] ME = TAG_W'(e);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q[e] <= '0;
            rdy_q[e]  <= (e == 0);
         end else if (rs_valid && rs_tag == ME) begin
            data_q[e] <= rs_value;
            rdy_q[e]  <= 1'b1;
         end else if (alloc_en && alloc_tag == ME) begin
            rdy_q[e]  <= 1'b0;
         end else if (wb_valid && wb_tag == ME) begin
            data_q[e] <= wb_value;
            rdy_q[e]  <= 1'b1;
         end
      end
   end

   logic hit;
   assign hit      = wb_valid && (wb_tag == rd_tag);
   assign rd_value = hit ? wb_value : data_q[rd_tag];
   assign rd_ready = hit | rdy_q[rd_tag];
   assign sv_value = data_q[sv_tag];
endmodule

// File: rtl/erb_rename.sv
module erb_rename
   import erb_pkg::*;
#(
   parameter int       DATA_W   = 32,
   parameter int       NUM_PHYS = 4,
   parameter rn_mode_e MODE     = ERB_RN_ALL,
   localparam int TAG_W = $clog2(NUM_PHYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rn_add_valid,
   input  logic              rn_add_mark,
   output logic              rn_stall,
   output logic [TAG_W-1:0]  rn_add_tag,
   output logic [TAG_W-1:0]  rn_mov_tag,
   input  logic              wb_valid,
   input  logic [TAG_W-1:0]  wb_tag,
   input  logic [DATA_W-1:0] wb_value,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_value,
   output logic              rd_ready,
   input  logic              cm_valid,
   input  logic [TAG_W-1:0]  cm_tag,
   input  logic              flush,
   input  logic              sv_wr_valid,
   input  logic [DATA_W-1:0] sv_wr_value,
   output logic [DATA_W-1:0] sv_rd_value
);
   if (NUM_PHYS < 2) begin : g_bad_phys
      $error("erb_rename: NUM_PHYS must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("erb_rename: DATA_W must be positive");
   end

   logic                need, none_free, alloc_en;
   logic [TAG_W-1:0]    pick_tag, spec_tag, comm_tag, comm_next;
   logic [NUM_PHYS-1:0] free_vec;

   if (MODE == ERB_RN_MARKED) begin : g_marked
      assign need = rn_add_valid & rn_add_mark;
   end else begin : g_all
      logic unused_mark;
      assign unused_mark = rn_add_mark;
      assign need = rn_add_valid;
   end

   assign rn_stall   = need & none_free;
   assign alloc_en   = need & ~none_free & ~flush;
   assign rn_add_tag = pick_tag;
   assign rn_mov_tag = spec_tag;

   erb_freelist #(.NUM_PHYS(NUM_PHYS)) u_free (
      .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en),
      .rel_en(cm_valid), .rel_tag(comm_tag),
      .flush(flush), .keep_tag(comm_next),
      .pick_tag(pick_tag), .none_free(none_free), .free_vec(free_vec)
   );

   erb_map #(.NUM_PHYS(NUM_PHYS)) u_map (
      .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_tag(pick_tag),
      .cm_valid(cm_valid), .cm_tag(cm_tag), .flush(flush),
      .spec_tag(spec_tag), .comm_tag(comm_tag), .comm_next(comm_next)
   );

   erb_store #(.NUM_PHYS(NUM_PHYS), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_tag(pick_tag),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
      .rs_valid(sv_wr_valid), .rs_tag(comm_tag), .rs_value(sv_wr_value),
      .rd_tag(rd_tag), .rd_value(rd_value), .rd_ready(rd_ready),
      .sv_tag(comm_tag), .sv_value(sv_rd_value)
   );
endmodule

// File: rtl/erb_rename_chk.sv
module erb_rename_chk #(
   parameter int NUM_PHYS = 4,
   localparam int TAG_W = $clog2(NUM_PHYS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rn_stall,
   input logic                alloc_en,
   input logic [TAG_W-1:0]    rn_add_tag,
   input logic [TAG_W-1:0]    spec_tag,
   input logic [TAG_W-1:0]    comm_tag,
   input logic [NUM_PHYS-1:0] free_vec,
   input logic                cm_valid,
   input logic                flush,
   input logic                wb_valid,
   input logic [TAG_W-1:0]    wb_tag,
   input logic [TAG_W-1:0]    rd_tag,
   input logic                rd_ready
);
   // R4
   stall_only_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rn_stall |-> (free_vec == '0));
   // R2
   alloc_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> (rn_add_tag != spec_tag) && free_vec[rn_add_tag]);
   // R9
   flush_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !cm_valid) |=> (spec_tag == comm_tag));
   // R8
   committed_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !free_vec[comm_tag] && ($countones(free_vec) <= NUM_PHYS - 1));
   // R6
   bypass_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_tag == rd_tag) |-> rd_ready);
endmodule

bind erb_rename erb_rename_chk #(.NUM_PHYS(NUM_PHYS)) u_chk (
   .clk(clk), .rst_n(rst_n), .rn_stall(rn_stall), .alloc_en(alloc_en),
   .rn_add_tag(rn_add_tag), .spec_tag(spec_tag), .comm_tag(comm_tag),
   .free_vec(free_vec), .cm_valid(cm_valid), .flush(flush),
   .wb_valid(wb_valid), .wb_tag(wb_tag), .rd_tag(rd_tag), .rd_ready(rd_ready)
);

// File: tb/tb_erb_rename.sv
module tb_erb_rename;
   import erb_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        av[2], mk[2], fl[2], wbv[2], cmv[2], svw[2];
   logic [1:0]  wbt[2], cmt[2], rdt[2];
   logic [31:0] wbd[2], svd[2];
   logic        st[2], rr[2];
   logic [1:0]  at[2], mt[2];
   logic [31:0] rv[2], sr[2];

   int total = 0;
   int bad = 0;

   erb_rename #(.DATA_W(32), .NUM_PHYS(4), .MODE(ERB_RN_ALL)) dut (
      .clk(clk), .rst_n(rst_n), .rn_add_valid(av[0]), .rn_add_mark(mk[0]),
      .rn_stall(st[0]), .rn_add_tag(at[0]), .rn_mov_tag(mt[0]),
      .wb_valid(wbv[0]), .wb_tag(wbt[0]), .wb_value(wbd[0]),
      .rd_tag(rdt[0]), .rd_value(rv[0]), .rd_ready(rr[0]),
      .cm_valid(cmv[0]), .cm_tag(cmt[0]), .flush(fl[0]),
      .sv_wr_valid(svw[0]), .sv_wr_value(svd[0]), .sv_rd_value(sr[0]));

   erb_rename #(.DATA_W(32), .NUM_PHYS(4), .MODE(ERB_RN_MARKED)) dut_mk (
      .clk(clk), .rst_n(rst_n), .rn_add_valid(av[1]), .rn_add_mark(mk[1]),
      .rn_stall(st[1]), .rn_add_tag(at[1]), .rn_mov_tag(mt[1]),
      .wb_valid(wbv[1]), .wb_tag(wbt[1]), .wb_value(wbd[1]),
      .rd_tag(rdt[1]), .rd_value(rv[1]), .rd_ready(rr[1]),
      .cm_valid(cmv[1]), .cm_tag(cmt[1]), .flush(fl[1]),
      .sv_wr_valid(svw[1]), .sv_wr_value(svd[1]), .sv_rd_value(sr[1]));

   // behavioural reference
   logic [31:0] m_data[2][4];
   bit          m_rdy[2][4];
   bit   [3:0]  m_free[2];
   int          m_spec[2], m_comm[2];
   int          pend0[$], pend1[$], ord0[$], ord1[$];

   function automatic int lowest(bit [3:0] f);
      for (int k = 3; k >= 0; k--) if (f[k]) lowest = k;
      if (f == 0) lowest = 0;
   endfunction

   task automatic chk(string req, string what, int i, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s inst%0d act=%0h exp=%0h", req, what, i, act, exp);
      end
   endtask

   task automatic drop_tag(int i, int t);
      if (i == 0) begin
         foreach (pend0[k]) if (pend0[k] == t) begin pend0.delete(k); break; end
      end else begin
         foreach (pend1[k]) if (pend1[k] == t) begin pend1.delete(k); break; end
      end
   endtask

   always @(posedge clk) begin
      for (int i = 0; i < 2; i++) begin
         if (!rst_n) begin
            for (int e = 0; e < 4; e++) begin m_data[i][e] = 0; m_rdy[i][e] = (e == 0); end
            m_free[i] = 4'b1110; m_spec[i] = 0; m_comm[i] = 0;
            pend0.delete(); pend1.delete(); ord0.delete(); ord1.delete();
         end else begin
            bit need, alloc;
            int a, cn;
            need  = av[i] && (i == 0 || mk[i]);
            alloc = need && (m_free[i] != 0) && !fl[i];
            a     = lowest(m_free[i]);
            if (wbv[i] && !(alloc && int'(wbt[i]) == a) && !(svw[i] && int'(wbt[i]) == m_comm[i])) begin
               m_data[i][wbt[i]] = wbd[i]; m_rdy[i][wbt[i]] = 1;
            end
            if (wbv[i]) drop_tag(i, int'(wbt[i]));
            if (alloc) m_rdy[i][a] = 0;
            if (svw[i]) begin m_data[i][m_comm[i]] = svd[i]; m_rdy[i][m_comm[i]] = 1; end
            cn = cmv[i] ? int'(cmt[i]) : m_comm[i];
            if (cmv[i]) begin
               if (i == 0) void'(ord0.pop_front()); else void'(ord1.pop_front());
            end
            if (fl[i]) begin
               m_free[i] = 4'b1111; m_free[i][cn] = 0; m_spec[i] = cn;
               if (i == 0) begin pend0.delete(); ord0.delete(); end
               else begin pend1.delete(); ord1.delete(); end
            end else begin
               if (alloc) begin
                  m_free[i][a] = 0; m_spec[i] = a;
                  if (i == 0) begin pend0.push_back(a); ord0.push_back(a); end
                  else begin pend1.push_back(a); ord1.push_back(a); end
               end
               if (cmv[i]) m_free[i][m_comm[i]] = 1;
            end
            m_comm[i] = cn;
         end
      end
   end

   task automatic compare();
      for (int i = 0; i < 2; i++) begin
         bit need, hit;
         need = av[i] && (i == 0 || mk[i]);
         chk("R4", "stall", i, 32'(st[i]), 32'(need && m_free[i] == 0));
         if (need && m_free[i] != 0) chk("R2", "add_tag", i, 32'(at[i]), 32'(lowest(m_free[i])));
         chk("R3", "mov_tag", i, 32'(mt[i]), 32'(m_spec[i]));
         hit = wbv[i] && wbt[i] == rdt[i];
         if (hit) begin
            chk("R6", "rd_value", i, rv[i], wbd[i]);
            chk("R6", "rd_ready", i, 32'(rr[i]), 32'd1);
         end else begin
            chk("R7", "rd_ready", i, 32'(rr[i]), 32'(m_rdy[i][rdt[i]]));
            if (m_rdy[i][rdt[i]]) chk("R5", "rd_value", i, rv[i], m_data[i][rdt[i]]);
         end
         chk("R8", "sv_rd_value", i, sr[i], m_data[i][m_comm[i]]);
      end
   endtask

   task automatic idle();
      for (int i = 0; i < 2; i++) begin
         av[i] = 0; mk[i] = 0; fl[i] = 0; wbv[i] = 0; cmv[i] = 0; svw[i] = 0;
         wbt[i] = 0; cmt[i] = 0; rdt[i] = 0; wbd[i] = 0; svd[i] = 0;
      end
   endtask

   task automatic step();
      compare();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1 reset state
      for (int i = 0; i < 2; i++) begin
         chk("R1", "mov_tag", i, 32'(mt[i]), 0);
         chk("R1", "sv_rd_value", i, sr[i], 0);
         chk("R1", "rd_ready", i, 32'(rr[i]), 1);
         chk("R1", "rd_value", i, rv[i], 0);
      end
      step();
      // add on both, unmarked; R3 move same cycle sees old map
      av[0] = 1; av[1] = 1; #1;
      chk("R3", "mov_tag same cycle", 0, 32'(mt[0]), 0);
      chk("R2", "add_tag", 0, 32'(at[0]), 1);
      step(); idle(); rdt[0] = 1; #1;
      chk("R2", "mov_tag after add", 0, 32'(mt[0]), 1);
      chk("R10", "unmarked add no rename", 1, 32'(mt[1]), 0);
      chk("R7", "fresh entry not ready", 0, 32'(rr[0]), 0);
      step();
      // R6 bypass
      wbv[0] = 1; wbt[0] = 1; wbd[0] = 32'h3f80_0000; rdt[0] = 1;
      av[1] = 1; mk[1] = 1; #1;
      chk("R6", "bypass value", 0, rv[0], 32'h3f80_0000);
      chk("R6", "bypass ready", 0, 32'(rr[0]), 1);
      step(); idle(); rdt[0] = 1; #1;
      chk("R5", "stored value", 0, rv[0], 32'h3f80_0000);
      chk("R10", "marked add renamed", 1, 32'(mt[1]), 1);
      step();
      // R8 commit
      cmv[0] = 1; cmt[0] = 1; #1; step(); idle(); #1;
      chk("R8", "committed value", 0, sr[0], 32'h3f80_0000);
      step();
      // fill pool: entries 0, 2, 3 then stall
      for (int n = 0; n < 3; n++) begin av[0] = 1; #1; step(); end
      av[0] = 1; #1;
      chk("R4", "stall when pool empty", 0, 32'(st[0]), 1);
      step(); idle(); #1;
      chk("R4", "stalled add kept map", 0, 32'(mt[0]), 3);
      step();
      // R9 flush with an add in the same cycle
      fl[0] = 1; av[0] = 1; #1; step(); idle(); #1;
      chk("R9", "map restored", 0, 32'(mt[0]), 1);
      step();
      av[0] = 1; #1;
      chk("R9", "entries freed", 0, 32'(at[0]), 0);
      step(); idle();
      // R11 restore
      svw[0] = 1; svd[0] = 32'h0000_0005; #1; step(); idle(); #1;
      chk("R11", "restored value", 0, sr[0], 32'h0000_0005);
      step();
      // random phase
      for (int c = 0; c < 4000; c++) begin
         for (int i = 0; i < 2; i++) begin
            int np, no;
            np = (i == 0) ? pend0.size() : pend1.size();
            no = (i == 0) ? ord0.size() : ord1.size();
            av[i] = ($urandom % 2) == 0;
            mk[i] = ($urandom % 2) == 0;
            fl[i] = ($urandom % 40) == 0;
            wbv[i] = (np > 0) && (($urandom % 2) == 0);
            if (np > 0) wbt[i] = 2'((i == 0) ? pend0[$urandom % np] : pend1[$urandom % np]);
            wbd[i] = $urandom;
            cmv[i] = 0;
            if (no > 0) begin
               cmt[i] = 2'((i == 0) ? ord0[0] : ord1[0]);
               cmv[i] = m_rdy[i][cmt[i]] && (($urandom % 3) == 0);
            end
            rdt[i] = 2'($urandom % 4);
            svw[i] = ($urandom % 100) == 0;
            svd[i] = $urandom;
         end
         #1;
         step();
      end
      idle();
      #1; step();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule